// File: doc/BRIEF.md
# Grayscale 3x3 Morphological Filter

This block filters a grayscale image that arrives as a raster-ordered stream of 8-bit pixels, one pixel per cycle at most, qualified by a valid strobe. For every input pixel that completes a full 3x3 neighbourhood it emits one filtered pixel with its own valid strobe. The stream suits a byte-wide serial transmitter. A select input chooses the operation. Dilation replaces each neighbourhood with its brightest pixel and erosion with its darkest.

Line history sits in three row banks, each as wide as the image. Incoming lines fill the banks in rotation. For each accepted pixel the two older lines are read at the current column, and together with the incoming pixel they are shifted into a 3x3 window register. The window is reduced by a registered two-level tree. The first level reduces each window row to one value, and the second level combines the three row results. No border padding is applied, so a 128x128 frame yields 126x126 results. The block returns to its start state by itself after the last pixel of a frame, so frames may follow each other with no idle cycle.

Top module: `morph_filter3x3`

## Requirements
- R1: A synchronous active-low reset drives out_valid and out_pix to 0. It also returns the column counter, the row counter and the bank pointer to the start, so the first pixel accepted after reset is row 0, column 0 of a new frame, even if reset arrived mid-frame.
- R2: No result is produced for any pixel in rows 0 or 1 or in columns 0 or 1. The first result of a frame belongs to the pixel at row 2, column 2 (rows and columns counted from 0).
- R3: Exactly one result is produced for every accepted pixel at row >= 2 and column >= 2, in raster order, giving (IMG_W-2)*(IMG_H-2) results per frame.
- R4: A result becomes visible on out_valid/out_pix right after the second rising edge following the edge that accepts the pixel completing its window. That edge loads the window, and the next two edges load the row stage and the output stage.
- R5: With op_sel = 0 (dilation), the result for the pixel at row r, column c is the maximum of the nine pixels at rows r-2..r and columns c-2..c.
- R6: With op_sel = 1 (erosion), the result is the minimum of those same nine pixels.
- R7: Lines are written to three banks in rotation (0, 1, 2, 0, ...), and the pointer advances after the last column of each line. Window rows are taken from the oldest bank, then the middle bank, then the incoming pixel, so results stay correct for every row after the banks wrap.
- R8: Accepting the pixel at row IMG_H-1, column IMG_W-1 ends the frame and returns all counters and the bank pointer to the start. The very next accepted pixel, even on the following cycle, is row 0, column 0 of a new frame.
- R9: in_pix and op_sel are ignored in cycles with in_valid low. The operation applied to a result is the op_sel value presented together with the pixel that completes its window.
- R10: out_pix holds the last result unchanged in every cycle where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W (8) | Input grayscale pixel, raster order |
| op_sel | input | 1 | 0 = dilation (maximum), 1 = erosion (minimum) |
| out_valid | output | 1 | Result strobe |
| out_pix | output | PIX_W (8) | Filtered pixel |

## Verification
Five patterns are used, and each exposes a different fault. A diagonal ramp gives every window a distinct, position-dependent extreme, so a swapped bank, a column that is off by one or a bad wrap changes the value seen. Uniformly random frames in both modes exercise the compare trees on arbitrary orderings. A bright field with isolated dark spots under erosion shows whether each spot spreads to exactly its 3x3 footprint. A frame with random idle gaps and a per-pixel random operation, with junk on the data and select lines while idle, shows whether ignored cycles leak into the line state or the chosen operation. Back-to-back frames and a reset in the middle of a frame check that the row and column positions restart correctly.

// File: rtl/morph_pkg.sv
// Shared types for the 3x3 morphological filter.
// Assumes: one operation select bit, 0 = maximum, 1 = minimum.
package morph_pkg;

    typedef enum logic {
        OP_MAX = 1'b0,
        OP_MIN = 1'b1
    } morph_op_e;

    localparam int unsigned WIN_DIM = 3;

endpackage

// File: rtl/morph_reduce3.sv
// Combinational three-input reducer: returns the largest or smallest input.
// Assumes: unsigned pixel values.
module morph_reduce3
    import morph_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    input  logic [PIX_W-1:0] c,
    input  morph_op_e        op,
    output logic [PIX_W-1:0] y
);

    logic [PIX_W-1:0] ab;

    // pick the winner of the first pair, then of that winner against c
    always_comb begin
        if (op == OP_MAX) begin
            ab = (a > b) ? a : b;
            y  = (ab > c) ? ab : c;
        end else begin
            ab = (a < b) ? a : b;
            y  = (ab < c) ? ab : c;
        end
    end

endmodule

// File: rtl/morph_line_store.sv
// Line storage and window former.
// Three full-width row banks take whole lines in rotation. For each accepted
// pixel the oldest and middle banks are read at the current column and shifted
// with the incoming pixel into a 3x3 window register.
// Assumes: raster-order input, IMG_W >= 3, IMG_H >= 3; the banks need no reset
// because no window is declared valid before the banks it reads were written.
module morph_line_store
    import morph_pkg::*;
#(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned IMG_W = 128,
    parameter int unsigned IMG_H = 128
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [PIX_W-1:0]                      in_pix,
    input  morph_op_e                             in_op,
    output logic                                  win_valid,
    output logic [WIN_DIM-1:0][WIN_DIM-1:0][PIX_W-1:0] win,
    output morph_op_e                             win_op
);

    localparam int unsigned COL_W    = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int unsigned ROW_W    = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam int unsigned N_BANK   = WIN_DIM;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);
    localparam logic [COL_W-1:0] COL_FIRST_OUT = COL_W'(WIN_DIM - 1);
    localparam logic [ROW_W-1:0] ROW_FIRST_OUT = ROW_W'(WIN_DIM - 1);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [1:0]       wr_ptr_q;
    logic [1:0]       old_idx;
    logic [1:0]       mid_idx;
    logic [N_BANK-1:0][PIX_W-1:0] rd_pix;
    logic             line_end;
    logic             frame_end;
    logic             win_ready;

    assign line_end  = (col_q == COL_LAST);
    assign frame_end = line_end && (row_q == ROW_LAST);
    assign win_ready = (col_q >= COL_FIRST_OUT) && (row_q >= ROW_FIRST_OUT);

    // oldest bank follows the one being written, middle bank precedes it
    always_comb begin
        old_idx = (wr_ptr_q == 2'd2) ? 2'd0 : wr_ptr_q + 2'd1;
        mid_idx = (wr_ptr_q == 2'd0) ? 2'd2 : wr_ptr_q - 2'd1;
    end

    // one storage array per bank; written only while it is the current bank
    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic [PIX_W-1:0] mem [IMG_W];

        // store the accepted pixel at the current column of this bank
        always_ff @(posedge clk) begin
            if (in_valid && (wr_ptr_q == 2'(b))) begin
                mem[col_q] <= in_pix;
            end
        end

        assign rd_pix[b] = mem[col_q];
    end

    // column, row and bank pointer advance per accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q    <= '0;
            row_q    <= '0;
            wr_ptr_q <= 2'd0;
        end else if (in_valid) begin
            if (frame_end) begin
                col_q    <= '0;
                row_q    <= '0;
                wr_ptr_q <= 2'd0;
            end else if (line_end) begin
                col_q    <= '0;
                row_q    <= row_q + 1'b1;
                wr_ptr_q <= (wr_ptr_q == 2'd2) ? 2'd0 : wr_ptr_q + 2'd1;
            end else begin
                col_q    <= col_q + 1'b1;
            end
        end
    end

    // shift the window left by one column and load the new right column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win       <= '0;
            win_valid <= 1'b0;
            win_op    <= OP_MAX;
        end else begin
            win_valid <= in_valid && win_ready;
            if (in_valid) begin
                for (int r = 0; r < WIN_DIM; r++) begin
                    for (int c = 0; c < WIN_DIM - 1; c++) begin
                        win[r][c] <= win[r][c+1];
                    end
                end
                win[0][WIN_DIM-1] <= rd_pix[old_idx];
                win[1][WIN_DIM-1] <= rd_pix[mid_idx];
                win[2][WIN_DIM-1] <= in_pix;
                win_op            <= in_op;
            end
        end
    end

endmodule

// File: rtl/morph_reduce_tree.sv
// Two-stage registered reduction of a 3x3 window.
// Stage one reduces each window row to one value; stage two combines the
// three row results. The output register holds its value between results.
// Assumes: the operation travels with its window through both stages.
module morph_reduce_tree
    import morph_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       win_valid,
    input  logic [WIN_DIM-1:0][WIN_DIM-1:0][PIX_W-1:0] win,
    input  morph_op_e                                  win_op,
    output logic                                       res_valid,
    output logic [PIX_W-1:0]                           res_pix
);

    logic [WIN_DIM-1:0][PIX_W-1:0] row_res;
    logic [WIN_DIM-1:0][PIX_W-1:0] row_q;
    logic                          row_vld_q;
    morph_op_e                     row_op_q;
    logic [PIX_W-1:0]              fin_res;

    // first level: one reducer per window row
    for (genvar r = 0; r < WIN_DIM; r++) begin : g_row
        morph_reduce3 #(.PIX_W(PIX_W)) u_row_red (
            .a  (win[r][0]),
            .b  (win[r][1]),
            .c  (win[r][2]),
            .op (win_op),
            .y  (row_res[r])
        );
    end

    // register the row results with their operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q     <= '0;
            row_vld_q <= 1'b0;
            row_op_q  <= OP_MAX;
        end else begin
            row_vld_q <= win_valid;
            if (win_valid) begin
                row_q    <= row_res;
                row_op_q <= win_op;
            end
        end
    end

    // second level: combine the three row results
    morph_reduce3 #(.PIX_W(PIX_W)) u_fin_red (
        .a  (row_q[0]),
        .b  (row_q[1]),
        .c  (row_q[2]),
        .op (row_op_q),
        .y  (fin_res)
    );

    // output register, loaded only when a result is ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_pix   <= '0;
        end else begin
            res_valid <= row_vld_q;
            if (row_vld_q) begin
                res_pix <= fin_res;
            end
        end
    end

endmodule

// File: rtl/morph_filter3x3.sv
// Streaming 3x3 grayscale dilation / erosion.
// Accepts one raster-order pixel per in_valid cycle and emits one result per
// pixel that completes a full neighbourhood; no border padding.
// Assumes: frames are exactly IMG_W x IMG_H pixels; op_sel is sampled with
// each accepted pixel.
module morph_filter3x3
    import morph_pkg::*;
#(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned IMG_W = 128,
    parameter int unsigned IMG_H = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             op_sel,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    logic                                       win_valid;
    logic [WIN_DIM-1:0][WIN_DIM-1:0][PIX_W-1:0] win;
    morph_op_e                                  win_op;
    morph_op_e                                  in_op;

    assign in_op = morph_op_e'(op_sel);

    morph_line_store #(
        .PIX_W (PIX_W),
        .IMG_W (IMG_W),
        .IMG_H (IMG_H)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .in_op     (in_op),
        .win_valid (win_valid),
        .win       (win),
        .win_op    (win_op)
    );

    morph_reduce_tree #(
        .PIX_W (PIX_W)
    ) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win       (win),
        .win_op    (win_op),
        .res_valid (out_valid),
        .res_pix   (out_pix)
    );

endmodule

// File: rtl/morph_filter3x3_chk.sv
// Protocol checker for morph_filter3x3, attached by bind.
// Keeps its own raster position and a three-deep expectation pipe.
module morph_filter3x3_chk #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned IMG_W = 128,
    parameter int unsigned IMG_H = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix
);

    int unsigned cx;
    int unsigned cy;
    logic [2:0]  exp_pipe;
    logic        completes;

    assign completes = in_valid && (cx >= 2) && (cy >= 2);

    // independent raster position and expectation pipe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cx       <= 0;
            cy       <= 0;
            exp_pipe <= '0;
        end else begin
            exp_pipe <= {exp_pipe[1:0], completes};
            if (in_valid) begin
                if (cx == IMG_W - 1) begin
                    cx <= 0;
                    cy <= (cy == IMG_H - 1) ? 0 : cy + 1;
                end else begin
                    cx <= cx + 1;
                end
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R4 (also R3: one result per completing pixel, none otherwise)
    result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == exp_pipe[2]);

    // R2
    top_rows_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cy < 2)) |-> ##3 !out_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_pix));

endmodule

bind morph_filter3x3 morph_filter3x3_chk #(
    .PIX_W (PIX_W),
    .IMG_W (IMG_W),
    .IMG_H (IMG_H)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/morph_filter3x3_bench.sv
// Self-checking bench: random and directed frames checked against a
// software 3x3 maximum / minimum model.
module morph_filter3x3_bench;

    localparam int W     = 128;
    localparam int H     = 128;
    localparam int N_OUT = (W - 2) * (H - 2);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic       op_sel = 1'b0;
    logic       out_valid;
    logic [7:0] out_pix;

    always #5 clk = ~clk;

    morph_filter3x3 #(.PIX_W(8), .IMG_W(W), .IMG_H(H)) u_morph_filter3x3 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .op_sel    (op_sel),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    typedef struct {
        logic [7:0] pix;
        int         due;
        int         r;
        int         c;
        logic       op;
    } exp_t;

    logic [7:0] img   [H][W];
    logic       opmap [H][W];
    exp_t       expq[$];
    int         cyc = 0;
    int         n_checks = 0;
    int         n_fail = 0;
    int         outs_seen = 0;
    logic [7:0] last_out = '0;
    logic       mon_en = 1'b0;
    logic       mixed_ops = 1'b0;
    logic       done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    function automatic logic [7:0] ref_px(input int r, input int c, input logic op);
        logic [7:0] acc;
        acc = img[r][c];
        for (int dr = 0; dr < 3; dr++) begin
            for (int dc = 0; dc < 3; dc++) begin
                if (op ? (img[r-dr][c-dc] < acc) : (img[r-dr][c-dc] > acc))
                    acc = img[r-dr][c-dc];
            end
        end
        return acc;
    endfunction

    // pattern 0 ramp, 1 random, 2 bright field with dark spots;
    // opmode 0 dilation, 1 erosion, 2 random per pixel
    task automatic gen_frame(input int pattern, input int opmode);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                case (pattern)
                    0:       img[r][c] = 8'((r * 3 + c * 7) & 255);
                    1:       img[r][c] = 8'($urandom_range(255));
                    default: img[r][c] = ($urandom_range(96) == 0) ? 8'd0 : 8'd255;
                endcase
                opmap[r][c] = (opmode == 2) ? 1'($urandom_range(1)) : 1'(opmode);
            end
        end
    endtask

    // present one pixel after optional idle cycles carrying junk (R9)
    task automatic drive_frame(input int gap_pct);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                while (int'($urandom_range(99)) < gap_pct) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_pix   = 8'($urandom_range(255));
                    op_sel   = 1'($urandom_range(1));
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_pix   = img[r][c];
                op_sel   = opmap[r][c];
                if (r >= 2 && c >= 2)
                    expq.push_back('{pix: ref_px(r, c, opmap[r][c]), due: cyc + 3,
                                     r: r, c: c, op: opmap[r][c]});
            end
        end
    endtask

    task automatic idle_drain(input int frames);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        check(expq.size() == 0, "R3", "results still owed", expq.size(), 0);
        check(outs_seen == frames * N_OUT, "R3 R8", "result count", outs_seen, frames * N_OUT);
        outs_seen = 0;
    endtask

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (out_valid) begin
                outs_seen++;
                if (expq.size() == 0) begin
                    check(1'b0, "R3", "unexpected result", out_pix, -1);
                end else begin
                    exp_t e;
                    string vreq;
                    e = expq.pop_front();
                    if (mixed_ops)       vreq = "R9";
                    else if (e.r >= 3)   vreq = e.op ? "R6 R7" : "R5 R7";
                    else                 vreq = e.op ? "R6" : "R5";
                    check(out_pix == e.pix, vreq, "result value", out_pix, e.pix);
                    check(cyc == e.due, (e.r == 2 && e.c == 2) ? "R2" : "R4",
                          "result cycle", cyc, e.due);
                end
                last_out = out_pix;
            end else if (out_pix != last_out) begin
                check(1'b0, "R10", "held result", out_pix, last_out);
            end
        end
    end

    initial begin
        void'($urandom(32'h0003_3a71));
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(out_pix == 8'd0, "R1", "out_pix in reset", out_pix, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // partial frame then reset: no result may appear (rows 0,1 only)
        gen_frame(1, 0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix   = 8'($urandom_range(255));
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(outs_seen == 0, "R2", "results from top rows", outs_seen, 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after mid-frame reset", out_valid, 0);
        rst_n = 1'b1;

        // ramp dilation, then random erosion back to back (R8)
        gen_frame(0, 0);
        drive_frame(0);
        gen_frame(1, 1);
        drive_frame(0);
        idle_drain(2);

        // random dilation with idle gaps
        gen_frame(1, 0);
        drive_frame(25);
        idle_drain(1);

        // dark spots on bright field under erosion
        gen_frame(2, 1);
        drive_frame(10);
        idle_drain(1);

        // operation chosen per pixel with junk in idle cycles (R9)
        mixed_ops = 1'b1;
        gen_frame(1, 2);
        drive_frame(15);
        idle_drain(1);
        mixed_ops = 1'b0;

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            report();
            $finish;
        end
    end

endmodule